// File: doc/BRIEF.md
# Translation Buffer Pointer Register Block

This block holds the data-side memory-management registers that software uses to refill a software-managed translation storage buffer (a table of translations kept in memory). It stores the tag-access register, which holds the faulting virtual page and context. It also stores two banks of buffer base and configuration registers. One bank serves context zero and the other serves every nonzero context.

Two read-only offsets return a pointer into the in-memory buffer, one for each page-size set. The pointer is computed in the cycle of the read. A miss handler reads this pointer and fetches the matching buffer entry directly, with no address arithmetic in software.

Each access completes one cycle after it is issued. Offsets that do not exist, and writes to read-only offsets, return an error response instead of data.

Top module: `tsb_ptr_regs`

## Requirements
- R1: After reset every register reads as zero, and both pointer offsets return zero.
- R2: A write to a writable offset replaces the whole 64-bit register. Writable offsets are 0x30 (tag access), 0x40 (base, ctx-zero, set 0), 0x48 (base, ctx-zero, set 1), 0x50 (config, ctx-zero), 0x58 (base, ctx-nonzero, set 0), 0x60 (base, ctx-nonzero, set 1) and 0x68 (config, ctx-nonzero). A later read of the same offset returns the written value.
- R3: The pointer uses the ctx-zero base and config when tag-access bits 12:0 are all zero. Otherwise it uses the ctx-nonzero bank.
- R4: The pointer holds bits 63:13 of the selected base, with bits 12:0 cleared. OR'd into it is the tag-access value shifted right by 9 + 3 × (config bits 2:0).
- R5: Before the OR, the shifted tag value is masked to bit positions 4 through 12+S. S is base bits 3:0.
- R6: Reading offset 0x78 (set 1 pointer) with base bit 12 set also sets pointer bit 13+S. Offset 0x70 (set 0 pointer) ignores base bit 12.
- R7: Offset 0x00 is a read-only view of tag access. It returns tag-access bits 63:22 moved down to bits 41:0, with tag-access bits 12:0 placed at bits 60:48. All other bits are zero.
- R8: An access to an undefined offset, or a write to 0x00, 0x70 or 0x78, returns resp_err=1 with resp_rdata zero and changes no register.
- R9: Every request produces exactly one response, on the clock edge after the request. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response present, one cycle after the request |
| resp_rdata | output | 64 | Read data; zero on writes and errors |
| resp_err | output | 1 | Access rejected |

## Verification
The bench loads nonzero garbage into the bank that should not be used. A design that swaps the context-zero test would then produce a visibly wrong pointer. Vectors sweep the page-size code to its maximum of 7 and the size field to its maximum of 15. An off-by-one in the shift or the mask width therefore moves or drops pointer bits. The split bit is driven on both pointer offsets, so a design that applies it to set 0 fails. Writes to read-only offsets are followed by read-back of the tag access, which exposes an erroneous decode that corrupts state.

// File: rtl/tsb_ptr_regs.sv
module tsb_ptr_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  output logic [63:0]       resp_rdata,
  output logic              resp_err
);

  localparam logic [ADDR_W-1:0] OFS_TAG_VIEW = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_TAG      = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_Z_BASE0  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] OFS_Z_BASE1  = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] OFS_Z_CFG    = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] OFS_N_BASE0  = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] OFS_N_BASE1  = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] OFS_N_CFG    = ADDR_W'(8'h68);
  localparam logic [ADDR_W-1:0] OFS_PTR0     = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] OFS_PTR1     = ADDR_W'(8'h78);

  logic [63:0] tag_q, zb0_q, zb1_q, zcfg_q, nb0_q, nb1_q, ncfg_q;

  // pointer datapath
  logic        use_zero;
  logic [63:0] sel_cfg, sel_b0, sel_b1;
  logic [5:0]  shamt;
  logic [63:0] shifted, mask0, mask1, ptr0, ptr1, tag_view;

  assign use_zero = (tag_q[12:0] == 13'd0);
  assign sel_cfg  = use_zero ? zcfg_q : ncfg_q;
  assign sel_b0   = use_zero ? zb0_q  : nb0_q;
  assign sel_b1   = use_zero ? zb1_q  : nb1_q;
  assign shamt    = 6'd9 + 6'd3 * {3'd0, sel_cfg[2:0]};
  assign shifted  = tag_q >> shamt;

  function automatic logic [63:0] field_mask(input logic [3:0] sz);
    return ({64{1'b1}} << 4) & ~({64{1'b1}} << (6'd13 + {2'd0, sz}));
  endfunction

  assign mask0 = field_mask(sel_b0[3:0]);
  assign mask1 = field_mask(sel_b1[3:0]);
  assign ptr0  = {sel_b0[63:13], 13'd0} | (shifted & mask0);
  assign ptr1  = {sel_b1[63:13], 13'd0} | (shifted & mask1)
               | (sel_b1[12] ? (64'd1 << (6'd13 + {2'd0, sel_b1[3:0]})) : 64'd0);

  assign tag_view = {3'd0, tag_q[12:0], 6'd0, tag_q[63:22]};

  // decode
  logic        hit, wr_ok, err_n;
  logic [63:0] rd_n;

  always_comb begin
    hit  = 1'b1;
    wr_ok = 1'b1;
    rd_n = 64'd0;
    case (req_addr)
      OFS_TAG_VIEW: begin rd_n = tag_view; wr_ok = 1'b0; end
      OFS_TAG:      rd_n = tag_q;
      OFS_Z_BASE0:  rd_n = zb0_q;
      OFS_Z_BASE1:  rd_n = zb1_q;
      OFS_Z_CFG:    rd_n = zcfg_q;
      OFS_N_BASE0:  rd_n = nb0_q;
      OFS_N_BASE1:  rd_n = nb1_q;
      OFS_N_CFG:    rd_n = ncfg_q;
      OFS_PTR0:     begin rd_n = ptr0; wr_ok = 1'b0; end
      OFS_PTR1:     begin rd_n = ptr1; wr_ok = 1'b0; end
      default:      begin hit = 1'b0; wr_ok = 1'b0; end
    endcase
  end

  assign err_n = !hit || (req_write && !wr_ok);

  logic do_wr;
  assign do_wr = req_valid && req_write && !err_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      zb0_q  <= '0;
      zb1_q  <= '0;
      zcfg_q <= '0;
      nb0_q  <= '0;
      nb1_q  <= '0;
      ncfg_q <= '0;
    end else if (do_wr) begin
      case (req_addr)
        OFS_TAG:     tag_q  <= req_wdata;
        OFS_Z_BASE0: zb0_q  <= req_wdata;
        OFS_Z_BASE1: zb1_q  <= req_wdata;
        OFS_Z_CFG:   zcfg_q <= req_wdata;
        OFS_N_BASE0: nb0_q  <= req_wdata;
        OFS_N_BASE1: nb1_q  <= req_wdata;
        OFS_N_CFG:   ncfg_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && err_n;
      resp_rdata <= (req_valid && !req_write && !err_n) ? rd_n : 64'd0;
    end
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R9
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && resp_rdata == 64'd0)); // R8
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && err_n) |=>
      $stable({tag_q, zb0_q, zb1_q, zcfg_q, nb0_q, nb1_q, ncfg_q})); // R8
  AST_IDLE_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(tag_q)); // R2
  AST_PTR0_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err && $past(req_addr) == OFS_PTR0 && !$past(req_write))
      |-> resp_rdata[3:0] == 4'd0); // R5

endmodule

// File: tb/tb_tsb_ptr_regs.sv
module tb_tsb_ptr_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [63:0] resp_rdata;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tsb_ptr_regs #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .resp_err(resp_err));

  typedef struct packed {
    logic [63:0] tag;
    logic [63:0] base;
    logic [63:0] cfg;
    logic        set1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0000_0000_1234_6000, 64'h0000_00AB_CDE0_0000, 64'd0, 1'b0},
    '{64'h0000_0000_1234_6000, 64'h0000_0010_0000_1001, 64'd0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_E005, 64'h1234_5678_9ABC_E00F, 64'd7, 1'b0},
    '{64'hFFFF_FFFF_FFFF_E005, 64'h1234_5678_9ABC_F00F, 64'd7, 1'b1},
    '{64'hA5A5_5A5A_C3C3_2001, 64'h0F0F_0000_0000_0003, 64'h0000_0000_0000_00F3, 1'b0},
    '{64'hA5A5_5A5A_C3C3_2001, 64'h0F0F_0000_0000_1005, 64'd2, 1'b1},
    '{64'h8000_0000_0000_0000, 64'h0000_0000_0000_0007, 64'd5, 1'b0},
    '{64'h7654_3210_FEDC_A000, 64'hCAFE_0000_0000_1000, 64'd1, 1'b0}
  };

  function automatic logic [63:0] ref_ptr(input vec_t v);
    logic [63:0] m, p;
    int s = 9 + 3 * int'(v.cfg[2:0]);
    int sz = int'(v.base[3:0]);
    m = ({64{1'b1}} << 4) & ~({64{1'b1}} << (13 + sz));
    p = {v.base[63:13], 13'd0} | ((v.tag >> s) & m);
    if (v.set1 && v.base[12]) p |= 64'd1 << (13 + sz);
    return p;
  endfunction

  logic [63:0] got;
  logic        got_err, got_valid;

  task automatic access(input logic wr, input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    got = resp_rdata; got_err = resp_err; got_valid = resp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++; n_run++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    foreach (VECS[i]) begin end
    for (int k = 0; k < 16; k++) begin
      access(1'b0, 8'(k * 8), 64'd0);
      check("R1 reset read", got, 64'd0);
    end
    // R9: response timing and idle
    @(negedge clk);
    check("R9 no response when idle", {63'd0, resp_valid}, 64'd0);
    access(1'b0, 8'h30, 64'd0);
    check("R9 response after one cycle", {63'd0, got_valid}, 64'd1);
    @(negedge clk);
    check("R9 single response", {63'd0, resp_valid}, 64'd0);

    // vector table: R3 R4 R5 R6
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic zero = (v.tag[12:0] == 13'd0);
      access(1'b1, 8'h30, v.tag);
      access(1'b1, zero ? 8'h40 : 8'h58, v.base);
      access(1'b1, zero ? 8'h48 : 8'h60, v.base);
      access(1'b1, zero ? 8'h50 : 8'h68, v.cfg);
      access(1'b1, zero ? 8'h58 : 8'h40, ~v.base);
      access(1'b1, zero ? 8'h60 : 8'h48, ~v.base);
      access(1'b1, zero ? 8'h68 : 8'h50, ~v.cfg);
      access(1'b0, v.set1 ? 8'h78 : 8'h70, 64'd0);
      check("R3 R4 R5 R6 pointer vector", got, ref_ptr(v));
      if (v.set1) begin
        vec_t w = v; w.set1 = 1'b0;
        access(1'b0, 8'h70, 64'd0);
        check("R6 set0 ignores split bit", got, ref_ptr(w));
      end
    end

    // directed hand-computed pointers (R4 R5 R6)
    access(1'b1, 8'h30, 64'h0000_0000_1234_6000);
    access(1'b1, 8'h40, 64'h0000_0010_0000_1001);
    access(1'b1, 8'h48, 64'h0000_0010_0000_1001);
    access(1'b1, 8'h50, 64'd0);
    access(1'b0, 8'h78, 64'd0);
    check("R6 split pointer", got, 64'h0000_0010_0000_5A30);
    access(1'b0, 8'h70, 64'd0);
    check("R5 set0 pointer", got, 64'h0000_0010_0000_1A30);
    access(1'b1, 8'h40, 64'h0000_00AB_CDE0_0000);
    access(1'b0, 8'h70, 64'd0);
    check("R4 base plus shifted tag", got, 64'h0000_00AB_CDE0_1A30);

    // R3: nonzero context selects other bank
    access(1'b1, 8'h58, 64'h0000_0000_0000_0000);
    access(1'b1, 8'h68, 64'd0);
    access(1'b1, 8'h30, 64'h0000_0000_1234_6001);
    access(1'b0, 8'h70, 64'd0);
    check("R3 ctx-nonzero bank", got, 64'h0000_0000_0000_1A30);

    // R7 alias
    access(1'b1, 8'h30, 64'hDEAD_BEEF_1234_5ABC);
    access(1'b0, 8'h00, 64'd0);
    check("R7 tag view", got,
          (64'hDEAD_BEEF_1234_5ABC >> 22) | (64'h1ABC << 48));
    // R2 readback
    access(1'b0, 8'h30, 64'd0);
    check("R2 tag readback", got, 64'hDEAD_BEEF_1234_5ABC);
    access(1'b1, 8'h68, 64'h0123_4567_89AB_CDEF);
    access(1'b0, 8'h68, 64'd0);
    check("R2 config readback", got, 64'h0123_4567_89AB_CDEF);

    // R8 errors
    access(1'b1, 8'h00, 64'h1111);
    check("R8 write to view errs", {63'd0, got_err}, 64'd1);
    access(1'b1, 8'h70, 64'h2222);
    check("R8 write to ptr0 errs", {63'd0, got_err}, 64'd1);
    access(1'b1, 8'h78, 64'h3333);
    check("R8 write to ptr1 errs", {63'd0, got_err}, 64'd1);
    access(1'b0, 8'h38, 64'd0);
    check("R8 undefined read errs", {63'd0, got_err}, 64'd1);
    check("R8 undefined read data zero", got, 64'd0);
    access(1'b1, 8'h31, 64'h4444);
    check("R8 undefined write errs", {63'd0, got_err}, 64'd1);
    access(1'b0, 8'h30, 64'd0);
    check("R8 tag unchanged after errors", got, 64'hDEAD_BEEF_1234_5ABC);
    check("R8 valid read has no err", {63'd0, got_err}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule